// File: doc/BRIEF.md
# Chained Scatter-Gather Copy Channel

This block is one memory-to-memory copy channel. Software programs a source address, a destination address, an item count, a link pointer and a control word through a small word-wide register port, enables the block globally and sets the channel's run bit. The channel then moves items of one, two or four bytes. Each item is read from its byte lanes of a source word and written into the matching lanes of a destination word, with byte enables. After each item, each address steps up, steps down or holds.

When the count is exhausted and the link pointer is non-zero, the channel reads a four-word descriptor (source, destination, next link, control) from memory. It reloads its registers from that descriptor and carries on. A zero link ends the chain. The channel then clears its run bit and raises a terminal-count status bit. An unusable configuration, such as a misaligned address or a bad width or mode, raises an error status bit and stops the channel instead. Both status bits are cleared by writing a one to a clear register. A level interrupt output reflects them.

The memory port is word addressed. It issues one access per cycle, and read data returns on the cycle after the request. A select output tells the memory side which of two masters a given access belongs to.

Top module: `dma_chain_chan`

## Requirements
- R1: Register byte addresses: the channel block is at 0x100 + CH_ID*0x20, with control at +0x0, config at +0x4, source at +0x8, destination at +0xC, link at +0x10 and count at +0x14. Global registers are terminal-count status at 0x04, clear at 0x08, error status at 0x0C and global enable at 0x24. Status bits sit at bit CH_ID. All registers reset to zero. A read returns its data on reg_rdata one cycle after reg_rd.
- R2: The channel moves data only while control bit 0 and global enable bit 0 are both 1. While global enable is 0, no memory request is issued and the run bit stays set. Setting global enable to 1 lets the work resume.
- R3: Control bits 13:11 (source) and 10:8 (destination) give the item width: 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes. An item is taken from byte lanes starting at source address bits 1:0 and written to lanes starting at destination address bits 1:0. Byte enables are set on exactly those lanes, so other bytes of the destination word are untouched.
- R4: Control bits 6:5 (source) and 4:3 (destination) select the address mode: 0 = increment, 1 = decrement, 2 = fixed. The address moves by the item width in bytes after each item.
- R5: The count register drops by one per item. When it is zero and link bits 31:2 are zero, the channel clears control bit 0 and sets its terminal-count status bit.
- R6: When the count is zero and link bits 31:2 are non-zero, the channel reads four words from the word at link bits 31:2: source, destination, next link, control. It loads them and continues. A count of zero, whether programmed or loaded, goes straight to link handling without any data access.
- R7: Descriptor control word fields: count in bits CNT_W-1:0, destination master at bit 16, source master at bit 17, destination mode at 19:18, source mode at 21:20, destination width at 24:22, source width at 27:25, and interrupt enable at bit 28. These load control bits 1, 2, 4:3, 6:5, 10:8 and 13:11 respectively. Control bit 31 becomes the inverse of bit 28.
- R8: irq is 1 when terminal-count status is set and control bit 31 is 0, or when error status is set and config bit 0 is 0.
- R9: A write to 0x08 with bit CH_ID set clears both status bits of the channel. Other bits of that write have no effect.
- R10: The channel raises error status, clears control bit 0 and makes no further memory access if any of these holds: the source or destination address is not aligned to its width, the two widths differ, a width code is above 2, or a mode code is 3.
- R11: mem_msel equals control bit 2 on source reads, control bit 1 on destination writes, and link bit 0 on descriptor reads.
- R12: The destination register reads back the next destination address while the channel runs. Writes to channel registers while the channel is busy are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | MEM_AW | Word address |
| mem_wdata | output | 32 | Write data |
| mem_be | output | 4 | Byte enables of a write |
| mem_msel | output | 1 | Master select of the access |
| mem_rdata | input | 32 | Read data, one cycle after request |
| irq | output | 1 | Registered interrupt level |

## Verification
The bench runs byte items that decrement from the top lane of a word. A design with wrong lane shifts or enables would overwrite a neighbouring byte that has been preloaded with a known pattern. A fixed half-word source feeds an incrementing destination, which catches a design that steps a fixed address or writes the wrong half. A two-descriptor chain checks the field repacking and the inverted interrupt sense: a design that copied bit 28 straight across would leave the interrupt unmasked, and one that reordered the descriptor words would copy to the wrong place. Further cases cover a misaligned start and a width mismatch, a zero count, a paused global enable and a write that arrives while the channel is busy. In these cases a design that slips would touch memory or change a register it must leave alone.

// File: rtl/dma_pkg.sv
package dma_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_CHECK, ST_RD, ST_RWAIT, ST_WR, ST_LINK, ST_DRD, ST_DWAIT
  } dma_state_t;

  localparam int BYTES = 4;
  localparam logic [1:0] AM_INC = 2'd0;
  localparam logic [1:0] AM_DEC = 2'd1;
  localparam logic [1:0] AM_FIX = 2'd2;

  localparam logic [2:0] RI_CSR  = 3'd0;
  localparam logic [2:0] RI_CFG  = 3'd1;
  localparam logic [2:0] RI_SRC  = 3'd2;
  localparam logic [2:0] RI_DST  = 3'd3;
  localparam logic [2:0] RI_LINK = 3'd4;
  localparam logic [2:0] RI_CNT  = 3'd5;

  localparam logic [31:0] CSR_MASK = 32'h8000_3F7F;

  function automatic logic [31:0] step_addr(logic [31:0] a, logic [1:0] mode,
                                            logic [2:0] wcode);
    logic [31:0] sz;
    sz = 32'd1 << wcode[1:0];
    case (mode)
      AM_INC:  return a + sz;
      AM_DEC:  return a - sz;
      default: return a;
    endcase
  endfunction

  function automatic logic misaligned(logic [1:0] lo, logic [2:0] wcode);
    case (wcode)
      3'd0:    return 1'b0;
      3'd1:    return lo[0];
      3'd2:    return |lo;
      default: return 1'b1;
    endcase
  endfunction

  function automatic logic [31:0] desc_to_ctl(logic [31:0] d, logic run);
    logic [31:0] c;
    c        = '0;
    c[0]     = run;
    c[1]     = d[16];
    c[2]     = d[17];
    c[4:3]   = d[19:18];
    c[6:5]   = d[21:20];
    c[10:8]  = d[24:22];
    c[13:11] = d[27:25];
    c[31]    = ~d[28];
    return c;
  endfunction

endpackage

// File: rtl/dma_lane.sv
module dma_lane
  import dma_pkg::*;
(
  input  logic [31:0]      word_i,
  input  logic [1:0]       src_lo_i,
  input  logic [1:0]       dst_lo_i,
  input  logic [2:0]       sw_i,
  input  logic [2:0]       dw_i,
  input  logic [1:0]       smode_i,
  input  logic [1:0]       dmode_i,
  output logic [31:0]      wdata_o,
  output logic [BYTES-1:0] be_o,
  output logic             bad_o
);

  logic [31:0]      shifted;
  logic [31:0]      keep;
  logic [BYTES-1:0] mask;

  always_comb begin
    shifted = word_i >> {src_lo_i, 3'b000};
    mask    = '0;
    keep    = '0;
    for (int i = 0; i < BYTES; i++) begin
      if (i < (1 << sw_i[1:0])) mask[i] = 1'b1;
    end
    for (int i = 0; i < BYTES; i++) begin
      keep[8*i +: 8] = {8{mask[i]}};
    end
    wdata_o = (shifted & keep) << {dst_lo_i, 3'b000};
    be_o    = mask << dst_lo_i;
    bad_o   = misaligned(src_lo_i, sw_i) | misaligned(dst_lo_i, dw_i) |
              (sw_i != dw_i) | (&smode_i) | (&dmode_i);
  end

endmodule

// File: rtl/dma_glob.sv
module dma_glob #(
  parameter int CH_ID = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic en_wr_i,
  input  logic en_bit_i,
  input  logic clr_wr_i,
  input  logic clr_bit_i,
  input  logic set_tc_i,
  input  logic set_err_i,
  output logic gen_o,
  output logic tc_o,
  output logic err_o
);

  always_ff @(posedge clk) begin
    if (rst) begin
      gen_o <= 1'b0;
      tc_o  <= 1'b0;
      err_o <= 1'b0;
    end else begin
      if (en_wr_i) gen_o <= en_bit_i;
      if (set_tc_i) tc_o <= 1'b1;
      else if (clr_wr_i && clr_bit_i) tc_o <= 1'b0;
      if (set_err_i) err_o <= 1'b1;
      else if (clr_wr_i && clr_bit_i) err_o <= 1'b0;
    end
  end

  AST_CLR_TC: assert property (@(posedge clk) disable iff (rst)
    clr_wr_i && clr_bit_i && !set_tc_i |=> !tc_o); // R9
  AST_CLR_ERR: assert property (@(posedge clk) disable iff (rst)
    clr_wr_i && clr_bit_i && !set_err_i |=> !err_o); // R9
  AST_GEN_OFF: assert property (@(posedge clk) disable iff (rst)
    en_wr_i && !en_bit_i |=> !gen_o); // R2

endmodule

// File: rtl/dma_core.sv
module dma_core
  import dma_pkg::*;
#(
  parameter int CNT_W  = 12,
  parameter int MEM_AW = 30
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              gen_i,
  input  logic              wr_i,
  input  logic [2:0]        wr_idx_i,
  input  logic [31:0]       wdata_i,
  input  logic [31:0]       mem_rdata_i,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [MEM_AW-1:0] mem_addr_o,
  output logic [31:0]       mem_wdata_o,
  output logic [BYTES-1:0]  mem_be_o,
  output logic              mem_msel_o,
  output logic              set_tc_o,
  output logic              set_err_o,
  output logic [31:0]       ctl_o,
  output logic              cfg_o,
  output logic [31:0]       src_o,
  output logic [31:0]       dst_o,
  output logic [31:0]       link_o,
  output logic [CNT_W-1:0]  cnt_o
);

  dma_state_t        state;
  logic [31:0]       ctl, src, dst, link, word_q;
  logic [CNT_W-1:0]  cnt;
  logic              cfg_mask;
  logic [MEM_AW-1:0] dptr;
  logic              dsel;
  logic [1:0]        didx;
  logic              set_tc_q, set_err_q;
  logic [31:0]       lane_wdata;
  logic [BYTES-1:0]  lane_be;
  logic              cfg_bad;
  logic [31:0]       src_nxt, dst_nxt;

  dma_lane u_lane (
    .word_i   (word_q),
    .src_lo_i (src[1:0]),
    .dst_lo_i (dst[1:0]),
    .sw_i     (ctl[13:11]),
    .dw_i     (ctl[10:8]),
    .smode_i  (ctl[6:5]),
    .dmode_i  (ctl[4:3]),
    .wdata_o  (lane_wdata),
    .be_o     (lane_be),
    .bad_o    (cfg_bad)
  );

  assign src_nxt = step_addr(src, ctl[6:5], ctl[13:11]);
  assign dst_nxt = step_addr(dst, ctl[4:3], ctl[10:8]);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      ctl       <= '0;
      cfg_mask  <= 1'b0;
      src       <= '0;
      dst       <= '0;
      link      <= '0;
      cnt       <= '0;
      word_q    <= '0;
      dptr      <= '0;
      dsel      <= 1'b0;
      didx      <= '0;
      set_tc_q  <= 1'b0;
      set_err_q <= 1'b0;
    end else begin
      set_tc_q  <= 1'b0;
      set_err_q <= 1'b0;
      if (wr_i && state == ST_IDLE) begin
        case (wr_idx_i)
          RI_CSR:  ctl      <= wdata_i & CSR_MASK;
          RI_CFG:  cfg_mask <= wdata_i[0];
          RI_SRC:  src      <= wdata_i;
          RI_DST:  dst      <= wdata_i;
          RI_LINK: link     <= wdata_i;
          RI_CNT:  cnt      <= wdata_i[CNT_W-1:0];
          default: ;
        endcase
      end
      case (state)
        ST_IDLE: if (ctl[0] && gen_i) state <= ST_CHECK;
        ST_CHECK: begin
          if (cnt == '0) begin
            state <= ST_LINK;
          end else if (cfg_bad) begin
            ctl[0]    <= 1'b0;
            set_err_q <= 1'b1;
            state     <= ST_IDLE;
          end else begin
            state <= ST_RD;
          end
        end
        ST_RD: if (gen_i) state <= ST_RWAIT;
        ST_RWAIT: begin
          word_q <= mem_rdata_i;
          state  <= ST_WR;
        end
        ST_WR: if (gen_i) begin
          src   <= src_nxt;
          dst   <= dst_nxt;
          cnt   <= cnt - 1'b1;
          state <= ST_CHECK;
        end
        ST_LINK: begin
          if (link[31:2] == '0) begin
            ctl[0]   <= 1'b0;
            set_tc_q <= 1'b1;
            state    <= ST_IDLE;
          end else begin
            dptr  <= link[MEM_AW+1:2];
            dsel  <= link[0];
            didx  <= '0;
            state <= ST_DRD;
          end
        end
        ST_DRD: if (gen_i) state <= ST_DWAIT;
        ST_DWAIT: begin
          case (didx)
            2'd0: src  <= mem_rdata_i;
            2'd1: dst  <= mem_rdata_i;
            2'd2: link <= mem_rdata_i;
            default: begin
              cnt <= mem_rdata_i[CNT_W-1:0];
              ctl <= desc_to_ctl(mem_rdata_i, ctl[0]);
            end
          endcase
          if (didx == 2'd3) begin
            state <= ST_CHECK;
          end else begin
            didx  <= didx + 1'b1;
            state <= ST_DRD;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    mem_req_o   = gen_i && (state == ST_RD || state == ST_WR || state == ST_DRD);
    mem_we_o    = gen_i && (state == ST_WR);
    mem_wdata_o = lane_wdata;
    mem_be_o    = (state == ST_WR) ? lane_be : '0;
    case (state)
      ST_WR: begin
        mem_addr_o = dst[MEM_AW+1:2];
        mem_msel_o = ctl[1];
      end
      ST_DRD: begin
        mem_addr_o = dptr + MEM_AW'(didx);
        mem_msel_o = dsel;
      end
      default: begin
        mem_addr_o = src[MEM_AW+1:2];
        mem_msel_o = ctl[2];
      end
    endcase
  end

  assign set_tc_o  = set_tc_q;
  assign set_err_o = set_err_q;
  assign ctl_o     = ctl;
  assign cfg_o     = cfg_mask;
  assign src_o     = src;
  assign dst_o     = dst;
  assign link_o    = link;
  assign cnt_o     = cnt;

  AST_HOLD_PAUSED: assert property (@(posedge clk) disable iff (rst)
    state == ST_RD && !gen_i |=> state == ST_RD); // R2
  AST_BE_WIDTH: assert property (@(posedge clk) disable iff (rst)
    mem_we_o |-> $countones(mem_be_o) == (1 << ctl[12:11])); // R3
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
    state == ST_WR && gen_i |=> cnt == CNT_W'($past(cnt) - 1'b1)); // R5
  AST_TC_STOPS: assert property (@(posedge clk) disable iff (rst)
    set_tc_q |-> !ctl[0] && state == ST_IDLE); // R5
  AST_ERR_STOPS: assert property (@(posedge clk) disable iff (rst)
    set_err_q |-> !ctl[0] && !mem_req_o); // R10
  AST_DESC_DONE: assert property (@(posedge clk) disable iff (rst)
    state == ST_DWAIT && didx == 2'd3 |=> state == ST_CHECK); // R6

endmodule

// File: rtl/dma_chain_chan.sv
module dma_chain_chan
  import dma_pkg::*;
#(
  parameter int CH_ID  = 3,
  parameter int ADDR_W = 9,
  parameter int CNT_W  = 12,
  parameter int MEM_AW = 30
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [MEM_AW-1:0] mem_addr,
  output logic [31:0]       mem_wdata,
  output logic [3:0]        mem_be,
  output logic              mem_msel,
  input  logic [31:0]       mem_rdata,
  output logic              irq
);

  localparam logic [ADDR_W-1:0] CH_BASE  = ADDR_W'(32'h100 + CH_ID * 32'h20);
  localparam logic [ADDR_W-1:0] A_TC     = ADDR_W'(32'h04);
  localparam logic [ADDR_W-1:0] A_CLR    = ADDR_W'(32'h08);
  localparam logic [ADDR_W-1:0] A_ERR    = ADDR_W'(32'h0C);
  localparam logic [ADDR_W-1:0] A_EN     = ADDR_W'(32'h24);

  logic             ch_hit, gen, tc, err, set_tc, set_err, cfg_mask;
  logic [2:0]       ch_idx;
  logic [31:0]      ctl, src, dst, link, rd_mux;
  logic [CNT_W-1:0] cnt;

  assign ch_hit = (reg_addr[ADDR_W-1:5] == CH_BASE[ADDR_W-1:5]) && (reg_addr[1:0] == 2'b00);
  assign ch_idx = reg_addr[4:2];

  dma_glob #(.CH_ID(CH_ID)) u_glob (
    .clk       (clk),
    .rst       (rst),
    .en_wr_i   (reg_wr && reg_addr == A_EN),
    .en_bit_i  (reg_wdata[0]),
    .clr_wr_i  (reg_wr && reg_addr == A_CLR),
    .clr_bit_i (reg_wdata[CH_ID]),
    .set_tc_i  (set_tc),
    .set_err_i (set_err),
    .gen_o     (gen),
    .tc_o      (tc),
    .err_o     (err)
  );

  dma_core #(.CNT_W(CNT_W), .MEM_AW(MEM_AW)) u_core (
    .clk         (clk),
    .rst         (rst),
    .gen_i       (gen),
    .wr_i        (reg_wr && ch_hit),
    .wr_idx_i    (ch_idx),
    .wdata_i     (reg_wdata),
    .mem_rdata_i (mem_rdata),
    .mem_req_o   (mem_req),
    .mem_we_o    (mem_we),
    .mem_addr_o  (mem_addr),
    .mem_wdata_o (mem_wdata),
    .mem_be_o    (mem_be),
    .mem_msel_o  (mem_msel),
    .set_tc_o    (set_tc),
    .set_err_o   (set_err),
    .ctl_o       (ctl),
    .cfg_o       (cfg_mask),
    .src_o       (src),
    .dst_o       (dst),
    .link_o      (link),
    .cnt_o       (cnt)
  );

  always_comb begin
    rd_mux = '0;
    if (ch_hit) begin
      case (ch_idx)
        RI_CSR:  rd_mux = ctl;
        RI_CFG:  rd_mux = {31'd0, cfg_mask};
        RI_SRC:  rd_mux = src;
        RI_DST:  rd_mux = dst;
        RI_LINK: rd_mux = link;
        RI_CNT:  rd_mux = 32'(cnt);
        default: rd_mux = '0;
      endcase
    end else if (reg_addr == A_TC) begin
      rd_mux = 32'(tc) << CH_ID;
    end else if (reg_addr == A_ERR) begin
      rd_mux = 32'(err) << CH_ID;
    end else if (reg_addr == A_EN) begin
      rd_mux = {31'd0, gen};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
      irq       <= 1'b0;
    end else begin
      if (reg_rd) reg_rdata <= rd_mux;
      irq <= (tc && !ctl[31]) || (err && !cfg_mask);
    end
  end

  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (rst)
    !tc && !err |=> !irq); // R8

endmodule

// File: tb/tb_dma_chain_chan.sv
`timescale 1ns/1ps
module tb_dma_chain_chan;

  localparam int CH = 3;
  localparam logic [8:0] CB    = 9'h100 + 9'(CH * 32);
  localparam logic [8:0] R_CSR = CB;
  localparam logic [8:0] R_CFG = CB + 9'd4;
  localparam logic [8:0] R_SRC = CB + 9'd8;
  localparam logic [8:0] R_DST = CB + 9'd12;
  localparam logic [8:0] R_LNK = CB + 9'd16;
  localparam logic [8:0] R_CNT = CB + 9'd20;
  localparam logic [8:0] G_TC  = 9'h04;
  localparam logic [8:0] G_CLR = 9'h08;
  localparam logic [8:0] G_ERR = 9'h0C;
  localparam logic [8:0] G_EN  = 9'h24;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [8:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic        mem_req, mem_we, mem_msel, irq;
  logic [29:0] mem_addr;
  logic [31:0] mem_wdata, mem_rdata;
  logic [3:0]  mem_be;

  int total = 0;
  int bad = 0;
  int req_cnt = 0;
  int wr_cnt = 0;
  logic msel_desc = 1'b0, msel_wr800 = 1'b0, msel_rd700 = 1'b1, msel_rd720 = 1'b0;
  logic [31:0] mem [0:1023];

  always #2 clk = ~clk;

  dma_chain_chan #(.CH_ID(CH)) dut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_be(mem_be), .mem_msel(mem_msel),
    .mem_rdata(mem_rdata), .irq(irq)
  );

  always @(posedge clk) begin
    if (mem_req && !mem_we) mem_rdata <= mem[mem_addr[9:0]];
    if (mem_req && mem_we)
      for (int i = 0; i < 4; i++)
        if (mem_be[i]) mem[mem_addr[9:0]][8*i +: 8] <= mem_wdata[8*i +: 8];
  end

  always @(negedge clk) begin
    if (mem_req) req_cnt++;
    if (mem_req && mem_we) wr_cnt++;
    if (mem_req && !mem_we && mem_addr == 30'h240) msel_desc = mem_msel;
    if (mem_req && mem_we && mem_addr == 30'h200) msel_wr800 = mem_msel;
    if (mem_req && !mem_we && mem_addr == 30'h1C0) msel_rd700 = mem_msel;
    if (mem_req && !mem_we && mem_addr == 30'h1C8) msel_rd720 = mem_msel;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wreg(input logic [8:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rreg(input logic [8:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  function automatic logic [31:0] ctlw(int sw, int dw, int sm, int dm, int smst,
                                       int dmst, int irq_off);
    return (32'(irq_off) << 31) | (32'(sw) << 11) | (32'(dw) << 8) | (32'(sm) << 5) |
           (32'(dm) << 3) | (32'(smst) << 2) | (32'(dmst) << 1) | 32'd1;
  endfunction

  task automatic wait_done(input string req);
    logic [31:0] v;
    int n = 0;
    v = 32'd1;
    while (v[0] && n < 500) begin
      rreg(R_CSR, v);
      n++;
    end
    if (v[0]) chk(req, 32'd1, 32'd0);
    repeat (3) @(negedge clk);
  endtask

  task automatic setup(input logic [31:0] s, input logic [31:0] d, input logic [31:0] c,
                       input logic [31:0] l);
    wreg(R_SRC, s); wreg(R_DST, d); wreg(R_CNT, c); wreg(R_LNK, l);
  endtask

  task automatic t_reset;
    logic [31:0] v;
    rreg(R_CSR, v); chk("R1 csr reset", v, 0);
    rreg(R_SRC, v); chk("R1 src reset", v, 0);
    rreg(G_TC, v);  chk("R1 tc reset", v, 0);
    rreg(G_EN, v);  chk("R1 enable reset", v, 0);
    chk("R8 irq reset", 32'(irq), 0);
  endtask

  task automatic t_word_copy;
    logic [31:0] v;
    wreg(G_EN, 1);
    setup(32'h100, 32'h200, 4, 0);
    wreg(R_CSR, ctlw(2, 2, 0, 0, 0, 0, 0));
    wait_done("R5 word copy finishes");
    for (int i = 0; i < 4; i++) chk("R3 word copy data", mem[10'h80 + i], mem[10'h40 + i]);
    rreg(R_SRC, v); chk("R4 src incremented", v, 32'h110);
    rreg(R_DST, v); chk("R4 dst incremented", v, 32'h210);
    rreg(R_CNT, v); chk("R5 count zero", v, 0);
    rreg(G_TC, v);  chk("R5 tc status", v, 32'h1 << CH);
    chk("R8 irq on tc", 32'(irq), 1);
  endtask

  task automatic t_clear;
    logic [31:0] v;
    wreg(G_CLR, 32'h1 << (CH + 1));
    repeat (2) @(negedge clk);
    rreg(G_TC, v); chk("R9 other bit no clear", v, 32'h1 << CH);
    wreg(G_CLR, 32'h1 << CH);
    repeat (2) @(negedge clk);
    rreg(G_TC, v); chk("R9 tc cleared", v, 0);
    chk("R8 irq dropped", 32'(irq), 0);
  endtask

  task automatic t_byte_dec;
    logic [31:0] v;
    mem[10'hC0]  = 32'h4433_2211;
    mem[10'h100] = 32'hAAAA_AAAA;
    setup(32'h303, 32'h403, 3, 0);
    wreg(R_CSR, ctlw(0, 0, 1, 1, 0, 0, 0));
    wait_done("R4 byte dec finishes");
    chk("R3 byte lanes dec", mem[10'h100], 32'h4433_22AA);
    rreg(R_SRC, v); chk("R4 src decremented", v, 32'h300);
    rreg(R_DST, v); chk("R4 dst decremented", v, 32'h400);
    wreg(G_CLR, 32'h1 << CH);
  endtask

  task automatic t_half_fixed;
    logic [31:0] v;
    mem[10'h140] = 32'hBEEF_1234;
    mem[10'h180] = 32'h0;
    mem[10'h181] = 32'h5555_5555;
    setup(32'h502, 32'h600, 3, 0);
    wreg(R_CSR, ctlw(1, 1, 2, 0, 0, 0, 1));
    wait_done("R4 half fixed finishes");
    chk("R3 half word 0", mem[10'h180], 32'hBEEF_BEEF);
    chk("R3 half upper untouched", mem[10'h181], 32'h5555_BEEF);
    rreg(R_SRC, v); chk("R4 fixed src held", v, 32'h502);
    rreg(R_DST, v); chk("R4 dst by two", v, 32'h606);
    rreg(G_TC, v);  chk("R5 tc masked case", v, 32'h1 << CH);
    chk("R8 irq masked by bit31", 32'(irq), 0);
    wreg(G_CLR, 32'h1 << CH);
  endtask

  task automatic t_chain;
    logic [31:0] v;
    mem[10'h1C0] = 32'hCAFE_F00D;
    mem[10'h1C4] = 32'h0102_0304;
    mem[10'h1C5] = 32'h0506_0708;
    mem[10'h1C8] = 32'h0000_00EE;
    mem[10'h208] = 32'h9999_9999;
    mem[10'h240] = 32'h710; mem[10'h241] = 32'h810;
    mem[10'h242] = 32'h920; mem[10'h243] = 32'h1481_0002;
    mem[10'h248] = 32'h720; mem[10'h249] = 32'h820;
    mem[10'h24A] = 32'h0;   mem[10'h24B] = 32'h000A_0001;
    setup(32'h700, 32'h800, 1, 32'h901);
    wreg(R_CSR, ctlw(2, 2, 0, 0, 0, 1, 0));
    wait_done("R6 chain finishes");
    chk("R6 first block", mem[10'h200], 32'hCAFE_F00D);
    chk("R6 desc one w0", mem[10'h204], 32'h0102_0304);
    chk("R6 desc one w1", mem[10'h205], 32'h0506_0708);
    chk("R6 desc two byte fixed", mem[10'h208], 32'h9999_99EE);
    rreg(R_CSR, v); chk("R7 repacked control", v, 32'h8000_0014);
    rreg(R_LNK, v); chk("R6 link end", v, 0);
    rreg(R_SRC, v); chk("R7 src after byte", v, 32'h721);
    rreg(R_DST, v); chk("R7 dst fixed", v, 32'h820);
    chk("R8 irq off by bit28 zero", 32'(irq), 0);
    chk("R11 desc read select", 32'(msel_desc), 1);
    chk("R11 dst write select", 32'(msel_wr800), 1);
    chk("R11 src read select low", 32'(msel_rd700), 0);
    chk("R11 src read select loaded", 32'(msel_rd720), 1);
    wreg(G_CLR, 32'h1 << CH);
  endtask

  task automatic t_errors;
    logic [31:0] v;
    int w0;
    mem[10'h80] = 32'h1234_5678;
    w0 = wr_cnt;
    setup(32'h102, 32'h200, 2, 0);
    wreg(R_CSR, ctlw(2, 2, 0, 0, 0, 0, 0));
    wait_done("R10 misaligned stops");
    chk("R10 no write on error", 32'(wr_cnt - w0), 0);
    rreg(G_ERR, v); chk("R10 err status", v, 32'h1 << CH);
    rreg(R_CSR, v); chk("R10 run bit cleared", {31'd0, v[0]}, 0);
    chk("R8 irq on err", 32'(irq), 1);
    wreg(R_CFG, 1);
    repeat (2) @(negedge clk);
    chk("R8 err irq masked", 32'(irq), 0);
    wreg(R_CFG, 0);
    wreg(G_CLR, 32'h1 << CH);
    repeat (2) @(negedge clk);
    rreg(G_ERR, v); chk("R9 err cleared", v, 0);
    setup(32'h100, 32'h200, 2, 0);
    wreg(R_CSR, ctlw(2, 1, 0, 0, 0, 0, 0));
    wait_done("R10 width mismatch stops");
    rreg(G_ERR, v); chk("R10 width mismatch err", v, 32'h1 << CH);
    chk("R10 mismatch no write", 32'(wr_cnt - w0), 0);
    wreg(G_CLR, 32'h1 << CH);
  endtask

  task automatic t_pause;
    logic [31:0] v;
    int r0;
    mem[10'h280] = 32'h0;
    wreg(G_EN, 0);
    setup(32'h100, 32'hA00, 2, 0);
    r0 = req_cnt;
    wreg(R_CSR, ctlw(2, 2, 0, 0, 0, 0, 0));
    repeat (20) @(negedge clk);
    rreg(R_CSR, v); chk("R2 run bit held while paused", {31'd0, v[0]}, 1);
    chk("R2 no request while paused", 32'(req_cnt - r0), 0);
    chk("R2 no data while paused", mem[10'h280], 0);
    wreg(G_EN, 1);
    wait_done("R2 resumes");
    chk("R2 data after resume", mem[10'h280], mem[10'h40]);
    wreg(G_CLR, 32'h1 << CH);
  endtask

  task automatic t_busy;
    logic [31:0] v;
    setup(32'h100, 32'hB00, 16, 0);
    wreg(R_CSR, ctlw(2, 2, 0, 0, 0, 0, 0));
    repeat (20) @(negedge clk);
    rreg(R_DST, v);
    chk("R12 dst progressing", 32'(v > 32'hB00 && v < 32'hB40 && v[1:0] == 2'b00), 1);
    wreg(R_SRC, 32'h0);
    wait_done("R12 busy run finishes");
    rreg(R_SRC, v); chk("R12 busy write ignored", v, 32'h140);
    chk("R12 last word", mem[10'h2CF], mem[10'h4F]);
    wreg(G_CLR, 32'h1 << CH);
  endtask

  task automatic t_zero;
    logic [31:0] v;
    int w0;
    w0 = wr_cnt;
    setup(32'h100, 32'hC00, 0, 0);
    wreg(R_CSR, ctlw(2, 2, 0, 0, 0, 0, 0));
    wait_done("R6 zero count finishes");
    chk("R6 zero count no write", 32'(wr_cnt - w0), 0);
    rreg(G_TC, v); chk("R5 zero count tc", v, 32'h1 << CH);
    wreg(G_CLR, 32'h1 << CH);
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = 32'h0;
    for (int i = 0; i < 16; i++) mem[10'h40 + i] = 32'hA5000000 + 32'(i * 32'h01010101);
    repeat (4) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_word_copy();
    t_clear();
    t_byte_dec();
    t_half_fixed();
    t_chain();
    t_errors();
    t_pause();
    t_busy();
    t_zero();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule